// File: doc/BRIEF.md
# ACPI SCI event combiner

This block gathers power-management fixed events and general-purpose events into one level-sensitive system control interrupt (SCI). It holds a 16-bit fixed-event status register and its matching enable register. It also holds a small general-purpose event (GPE) block, byte addressed, with status bytes followed by enable bytes. Event sources raise status bits with single-cycle pulses. Firmware or the OS clears a status bit by writing 1 to it.

Only four fixed events can raise the interrupt: timer overflow, global lock, power button and real-time clock. On the GPE side only the slot-hotplug and processor-hotplug bits of the first status byte can raise it. Any other status bit is recorded and can be read back, but the interrupt never sees it. The block also drives an arm signal for the external PM timer's overflow interrupt. It tracks ACPI mode from the power-management command port and requests an SMI for any other command when SMIs are allowed.

Top module: `acpi_sci_combiner`

## Requirements
- R1: During reset and right after it, pm1_sts, pm1_en, all GPE status and enable bytes, sci, tmr_arm, acpi_mode and smi_req are all zero.
- R2: A 1 on pm1_evt[i] sets pm1_sts[i] at the next clock edge. On pm1_sts_wr, each 1 in pm1_wdata clears the matching status bit and each 0 leaves it unchanged. If a pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: pm1_en_wr loads all 16 bits of pm1_wdata into pm1_en, and the new value is visible after the next edge.
- R4: sci is high exactly when (pm1_sts & pm1_en) has bit 0 (timer), 5 (global lock), 8 (power button) or 10 (real-time clock) set, or when (GPE status byte 0 & GPE enable byte 0) has bit 1 or bit 2 set. No other bit pair affects sci. sci follows the registered state with no extra delay.
- R5: The GPE block is addressed through gpe_addr. Addresses 0 and 1 are the status bytes, little-endian: address 0 holds GPE bits 7:0 and address 1 holds bits 15:8. Addresses 2 and 3 are the enable bytes in the same order. gpe_rdata shows the addressed byte combinationally. A write to a status byte clears the bits written as 1. A write to an enable byte overwrites it. gpe_evt[k] sets status bit k, and set wins over clear.
- R6: gpe_evt[1] is the slot-hotplug event and gpe_evt[2] is the processor-hotplug event. Both are latched in status byte 0.
- R7: tmr_arm is high exactly when pm1_en[0] is 1 and pm1_sts[0] is 0.
- R8: An apm_wr with command 0xF1 sets acpi_mode at the next edge, and one with command 0xF0 clears it. Any other command leaves acpi_mode unchanged.
- R9: smi_req is high for the cycle after an apm_wr whose command is neither 0xF1 nor 0xF0 while smi_gate is 1. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm1_evt | input | 16 | Fixed-event pulses, one per status bit |
| pm1_sts_wr | input | 1 | Write-1-to-clear strobe for the fixed status register |
| pm1_en_wr | input | 1 | Load strobe for the fixed enable register |
| pm1_wdata | input | 16 | Write data for both fixed registers |
| pm1_sts | output | 16 | Fixed-event status |
| pm1_en | output | 16 | Fixed-event enable |
| gpe_evt | input | 16 | General-purpose event pulses (bit 1 slot hotplug, bit 2 processor hotplug) |
| gpe_wr | input | 1 | GPE byte write strobe |
| gpe_addr | input | 2 | GPE byte address |
| gpe_wdata | input | 8 | GPE write byte |
| gpe_rdata | output | 8 | GPE byte at gpe_addr |
| apm_wr | input | 1 | Power-management command strobe |
| apm_cmd | input | 8 | Power-management command value |
| smi_gate | input | 1 | Allows SMI requests for non-ACPI commands |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Arms the external timer-overflow interrupt |
| acpi_mode | output | 1 | ACPI mode flag |
| smi_req | output | 1 | One-cycle SMI request |

## Verification
The assertions expect event pulses and write strobes to be clean, known values on every clock edge after reset. They also expect a status bit that is pulsed and cleared in the same cycle to be judged by the set-wins rule, so each clearing property excludes a same-cycle event on that bit. The random stimulus keeps events sparse by ANDing several random words together. It draws commands mostly from 0xF0, 0xF1 and arbitrary bytes, and lets writes and pulses overlap freely. Directed cases target the overlap of clear and set, the bits that are masked out of the interrupt, and both enable bytes.

// File: rtl/acpi_sci_pkg.sv
package acpi_sci_pkg;

    localparam int PM1_W = 16;
    localparam int PM1_TMR_BIT = 0;
    localparam logic [PM1_W-1:0] PM1_SCI_MASK = 16'h0521;
    localparam logic [7:0] GPE0_SCI_MASK = 8'h06;
    localparam logic [7:0] CMD_ACPI_ON  = 8'hF1;
    localparam logic [7:0] CMD_ACPI_OFF = 8'hF0;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_ENTER = 2'd1,
        CMD_LEAVE = 2'd2,
        CMD_TRAP  = 2'd3
    } apm_kind_e;

    typedef struct packed {
        logic [PM1_W-1:0] sts;
        logic [PM1_W-1:0] en;
    } pm1_regs_t;

    function automatic apm_kind_e classify_cmd(input logic wr, input logic [7:0] cmd);
        if (!wr)                    return CMD_NONE;
        else if (cmd == CMD_ACPI_ON)  return CMD_ENTER;
        else if (cmd == CMD_ACPI_OFF) return CMD_LEAVE;
        else                        return CMD_TRAP;
    endfunction

    function automatic logic masked_hit16(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] m);
        return |(a & b & m);
    endfunction

    function automatic logic masked_hit8(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] m);
        return |(a & b & m);
    endfunction

endpackage

// File: rtl/acpi_pm1_regs.sv
module acpi_pm1_regs
    import acpi_sci_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PM1_W-1:0] evt,
    input  logic             sts_wr,
    input  logic             en_wr,
    input  logic [PM1_W-1:0] wdata,
    output logic [PM1_W-1:0] sts,
    output logic [PM1_W-1:0] en
);
    pm1_regs_t q;
    logic [PM1_W-1:0] clr_mask;

    assign clr_mask = sts_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.sts <= (q.sts & ~clr_mask) | evt;
            if (en_wr) q.en <= wdata;
        end
    end

    assign sts = q.sts;
    assign en  = q.en;
endmodule

// File: rtl/acpi_gpe_block.sv
module acpi_gpe_block #(
    parameter int STS_BYTES = 2,
    localparam int GW = 8 * STS_BYTES,
    localparam int AW = $clog2(2 * STS_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [GW-1:0] evt,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic [GW-1:0] sts_all,
    output logic [GW-1:0] en_all
);
    for (genvar b = 0; b < STS_BYTES; b++) begin : g_byte
        logic [7:0] s_q;
        logic [7:0] e_q;
        logic       hit_s;
        logic       hit_e;

        assign hit_s = wr && (addr == AW'(b));
        assign hit_e = wr && (addr == AW'(STS_BYTES + b));

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '0;
                e_q <= '0;
            end else begin
                s_q <= (s_q & ~(hit_s ? wdata : 8'h00)) | evt[8*b +: 8];
                if (hit_e) e_q <= wdata;
            end
        end

        assign sts_all[8*b +: 8] = s_q;
        assign en_all[8*b +: 8]  = e_q;
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < STS_BYTES; b++) begin
            if (addr == AW'(b))             rdata = sts_all[8*b +: 8];
            if (addr == AW'(STS_BYTES + b)) rdata = en_all[8*b +: 8];
        end
    end
endmodule

// File: rtl/acpi_sci_logic.sv
module acpi_sci_logic
    import acpi_sci_pkg::*;
(
    input  logic [PM1_W-1:0] pm1_sts,
    input  logic [PM1_W-1:0] pm1_en,
    input  logic [7:0]       gpe_sts0,
    input  logic [7:0]       gpe_en0,
    output logic             sci,
    output logic             tmr_arm
);
    logic fixed_hit;
    logic gpe_hit;

    assign fixed_hit = masked_hit16(pm1_sts, pm1_en, PM1_SCI_MASK);
    assign gpe_hit   = masked_hit8(gpe_sts0, gpe_en0, GPE0_SCI_MASK);
    assign sci       = fixed_hit | gpe_hit;
    assign tmr_arm   = pm1_en[PM1_TMR_BIT] & ~pm1_sts[PM1_TMR_BIT];
endmodule

// File: rtl/acpi_apm_ctl.sv
module acpi_apm_ctl
    import acpi_sci_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       apm_wr,
    input  logic [7:0] apm_cmd,
    input  logic       smi_gate,
    output logic       acpi_mode,
    output logic       smi_req
);
    apm_kind_e kind;

    assign kind = classify_cmd(apm_wr, apm_cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            acpi_mode <= 1'b0;
            smi_req   <= 1'b0;
        end else begin
            unique case (kind)
                CMD_ENTER: acpi_mode <= 1'b1;
                CMD_LEAVE: acpi_mode <= 1'b0;
                default:   acpi_mode <= acpi_mode;
            endcase
            smi_req <= (kind == CMD_TRAP) && smi_gate;
        end
    end
endmodule

// File: rtl/acpi_sci_combiner.sv
module acpi_sci_combiner
    import acpi_sci_pkg::*;
#(
    parameter int GPE_STS_BYTES = 2,
    localparam int GPE_W  = 8 * GPE_STS_BYTES,
    localparam int GPE_AW = $clog2(2 * GPE_STS_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PM1_W-1:0]  pm1_evt,
    input  logic              pm1_sts_wr,
    input  logic              pm1_en_wr,
    input  logic [PM1_W-1:0]  pm1_wdata,
    output logic [PM1_W-1:0]  pm1_sts,
    output logic [PM1_W-1:0]  pm1_en,
    input  logic [GPE_W-1:0]  gpe_evt,
    input  logic              gpe_wr,
    input  logic [GPE_AW-1:0] gpe_addr,
    input  logic [7:0]        gpe_wdata,
    output logic [7:0]        gpe_rdata,
    input  logic              apm_wr,
    input  logic [7:0]        apm_cmd,
    input  logic              smi_gate,
    output logic              sci,
    output logic              tmr_arm,
    output logic              acpi_mode,
    output logic              smi_req
);
    logic [GPE_W-1:0] gpe_sts_q;
    logic [GPE_W-1:0] gpe_en_q;

    acpi_pm1_regs u_pm1 (
        .clk    (clk),
        .rst    (rst),
        .evt    (pm1_evt),
        .sts_wr (pm1_sts_wr),
        .en_wr  (pm1_en_wr),
        .wdata  (pm1_wdata),
        .sts    (pm1_sts),
        .en     (pm1_en)
    );

    acpi_gpe_block #(.STS_BYTES(GPE_STS_BYTES)) u_gpe (
        .clk     (clk),
        .rst     (rst),
        .evt     (gpe_evt),
        .wr      (gpe_wr),
        .addr    (gpe_addr),
        .wdata   (gpe_wdata),
        .rdata   (gpe_rdata),
        .sts_all (gpe_sts_q),
        .en_all  (gpe_en_q)
    );

    acpi_sci_logic u_sci (
        .pm1_sts  (pm1_sts),
        .pm1_en   (pm1_en),
        .gpe_sts0 (gpe_sts_q[7:0]),
        .gpe_en0  (gpe_en_q[7:0]),
        .sci      (sci),
        .tmr_arm  (tmr_arm)
    );

    acpi_apm_ctl u_apm (
        .clk       (clk),
        .rst       (rst),
        .apm_wr    (apm_wr),
        .apm_cmd   (apm_cmd),
        .smi_gate  (smi_gate),
        .acpi_mode (acpi_mode),
        .smi_req   (smi_req)
    );
endmodule

// File: rtl/acpi_sci_checker.sv
module acpi_sci_checker #(
    parameter int GW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [15:0]   pm1_evt,
    input logic          pm1_sts_wr,
    input logic          pm1_en_wr,
    input logic [15:0]   pm1_wdata,
    input logic [15:0]   pm1_sts,
    input logic [15:0]   pm1_en,
    input logic [GW-1:0] gpe_evt,
    input logic [GW-1:0] gpe_sts,
    input logic [GW-1:0] gpe_en,
    input logic          apm_wr,
    input logic [7:0]    apm_cmd,
    input logic          sci,
    input logic          tmr_arm,
    input logic          acpi_mode,
    input logic          smi_req
);
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        pm1_evt[8] |=> pm1_sts[8]);

    p_w1c_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (pm1_sts_wr && pm1_wdata[5] && !pm1_evt[5]) |=> !pm1_sts[5]);

    p_en_load_r3: assert property (@(posedge clk) disable iff (rst)
        pm1_en_wr |=> (pm1_en == $past(pm1_wdata)));

    p_sci_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (pm1_en == 16'h0000 && gpe_en[7:0] == 8'h00) |-> !sci);

    p_hotplug_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (gpe_evt[1] || gpe_evt[2]) |=> (gpe_sts[2:1] != 2'b00));

    p_arm_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        pm1_sts[0] |-> !tmr_arm);

    p_mode_on_r8: assert property (@(posedge clk) disable iff (rst)
        (apm_wr && apm_cmd == 8'hF1) |=> acpi_mode);

    p_mode_off_r8: assert property (@(posedge clk) disable iff (rst)
        (apm_wr && apm_cmd == 8'hF0) |=> !acpi_mode);

    p_no_smi_acpi_r9: assert property (@(posedge clk) disable iff (rst)
        (apm_wr && (apm_cmd == 8'hF1 || apm_cmd == 8'hF0)) |=> !smi_req);

    p_smi_cause_r9: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $past(apm_wr));
endmodule

bind acpi_sci_combiner acpi_sci_checker #(.GW(GPE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pm1_evt    (pm1_evt),
    .pm1_sts_wr (pm1_sts_wr),
    .pm1_en_wr  (pm1_en_wr),
    .pm1_wdata  (pm1_wdata),
    .pm1_sts    (pm1_sts),
    .pm1_en     (pm1_en),
    .gpe_evt    (gpe_evt),
    .gpe_sts    (gpe_sts_q),
    .gpe_en     (gpe_en_q),
    .apm_wr     (apm_wr),
    .apm_cmd    (apm_cmd),
    .sci        (sci),
    .tmr_arm    (tmr_arm),
    .acpi_mode  (acpi_mode),
    .smi_req    (smi_req)
);

// File: tb/sim_acpi_sci_combiner.sv
module sim_acpi_sci_combiner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pm1_evt = '0;
    logic        pm1_sts_wr = 1'b0;
    logic        pm1_en_wr = 1'b0;
    logic [15:0] pm1_wdata = '0;
    logic [15:0] pm1_sts, pm1_en;
    logic [15:0] gpe_evt = '0;
    logic        gpe_wr = 1'b0;
    logic [1:0]  gpe_addr = '0;
    logic [7:0]  gpe_wdata = '0;
    logic [7:0]  gpe_rdata;
    logic        apm_wr = 1'b0;
    logic [7:0]  apm_cmd = '0;
    logic        smi_gate = 1'b0;
    logic        sci, tmr_arm, acpi_mode, smi_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] m_sts = '0, m_en = '0, m_gs = '0, m_ge = '0;
    logic        m_mode = 1'b0, m_smi = 1'b0;

    always #4 clk = ~clk;

    acpi_sci_combiner u0 (
        .clk(clk), .rst(rst),
        .pm1_evt(pm1_evt), .pm1_sts_wr(pm1_sts_wr), .pm1_en_wr(pm1_en_wr),
        .pm1_wdata(pm1_wdata), .pm1_sts(pm1_sts), .pm1_en(pm1_en),
        .gpe_evt(gpe_evt), .gpe_wr(gpe_wr), .gpe_addr(gpe_addr),
        .gpe_wdata(gpe_wdata), .gpe_rdata(gpe_rdata),
        .apm_wr(apm_wr), .apm_cmd(apm_cmd), .smi_gate(smi_gate),
        .sci(sci), .tmr_arm(tmr_arm), .acpi_mode(acpi_mode), .smi_req(smi_req)
    );

    function automatic logic exp_sci(input logic [15:0] s, input logic [15:0] e,
                                     input logic [15:0] gs, input logic [15:0] ge);
        return (|(s & e & 16'h0521)) | (|(gs[7:0] & ge[7:0] & 8'h06));
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a, input logic [15:0] gs,
                                          input logic [15:0] ge);
        case (a)
            2'd0: return gs[7:0];
            2'd1: return gs[15:8];
            2'd2: return ge[7:0];
            default: return ge[15:8];
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        pm1_evt = '0; pm1_sts_wr = 0; pm1_en_wr = 0; pm1_wdata = '0;
        gpe_evt = '0; gpe_wr = 0; gpe_wdata = '0;
        apm_wr = 0; apm_cmd = '0; smi_gate = 0;
    endtask

    task automatic tick();
        logic [7:0] clr;
        @(negedge clk);
        m_sts = (m_sts & ~(pm1_sts_wr ? pm1_wdata : 16'h0)) | pm1_evt;
        if (pm1_en_wr) m_en = pm1_wdata;
        for (int b = 0; b < 2; b++) begin
            clr = (gpe_wr && gpe_addr == 2'(b)) ? gpe_wdata : 8'h00;
            m_gs[8*b +: 8] = (m_gs[8*b +: 8] & ~clr) | gpe_evt[8*b +: 8];
            if (gpe_wr && gpe_addr == 2'(b + 2)) m_ge[8*b +: 8] = gpe_wdata;
        end
        if (apm_wr && apm_cmd == 8'hF1) m_mode = 1'b1;
        if (apm_wr && apm_cmd == 8'hF0) m_mode = 1'b0;
        m_smi = apm_wr && smi_gate && apm_cmd != 8'hF1 && apm_cmd != 8'hF0;
        chk("R2 pm1_sts", 32'(pm1_sts), 32'(m_sts));
        chk("R3 pm1_en", 32'(pm1_en), 32'(m_en));
        chk("R4 sci", 32'(sci), 32'(exp_sci(m_sts, m_en, m_gs, m_ge)));
        chk("R5 gpe_rdata", 32'(gpe_rdata), 32'(exp_rd(gpe_addr, m_gs, m_ge)));
        chk("R7 tmr_arm", 32'(tmr_arm), 32'(m_en[0] & ~m_sts[0]));
        chk("R8 acpi_mode", 32'(acpi_mode), 32'(m_mode));
        chk("R9 smi_req", 32'(smi_req), 32'(m_smi));
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_abcd));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 pm1_sts", 32'(pm1_sts), 0);
        chk("R1 pm1_en", 32'(pm1_en), 0);
        chk("R1 sci", 32'(sci), 0);
        chk("R1 tmr_arm", 32'(tmr_arm), 0);
        chk("R1 acpi_mode", 32'(acpi_mode), 0);
        chk("R1 smi_req", 32'(smi_req), 0);
        for (int a = 0; a < 4; a++) begin
            gpe_addr = 2'(a); #1;
            chk("R1 gpe byte", 32'(gpe_rdata), 0);
        end
        gpe_addr = 0;

        // R7/R3: enabling the timer arms it
        pm1_en_wr = 1; pm1_wdata = 16'h0001; tick();
        // R2/R4/R7: overflow sets status, raises sci, disarms
        pm1_evt = 16'h0001; tick();
        chk("R4 timer sci", 32'(sci), 1);
        chk("R7 disarmed", 32'(tmr_arm), 0);
        // R2: writing 0 leaves status; writing 1 clears
        pm1_sts_wr = 1; pm1_wdata = 16'h0000; tick();
        pm1_sts_wr = 1; pm1_wdata = 16'h0001; tick();
        chk("R2 cleared", 32'(pm1_sts[0]), 0);
        // R4: non-SCI fixed bit enabled and set -> no sci
        pm1_en_wr = 1; pm1_wdata = 16'hFFFF; tick();
        pm1_evt = 16'h0008; tick();
        chk("R4 masked fixed bit", 32'(sci), 0);
        // R2: set wins over clear on bit 5
        pm1_evt = 16'h0020; pm1_sts_wr = 1; pm1_wdata = 16'h0020; tick();
        chk("R2 set wins", 32'(pm1_sts[5]), 1);
        pm1_sts_wr = 1; pm1_wdata = 16'hFFFF; tick();
        pm1_en_wr = 1; pm1_wdata = 16'h0000; tick();
        // R5/R6/R4: GPE side
        gpe_wr = 1; gpe_addr = 2; gpe_wdata = 8'hFF; tick();
        gpe_wr = 1; gpe_addr = 3; gpe_wdata = 8'hFF; tick();
        gpe_addr = 0; gpe_evt = 16'h0001; tick();
        chk("R4 gpe bit0 masked", 32'(sci), 0);
        gpe_addr = 1; gpe_evt = 16'h0100; tick();
        chk("R4 gpe byte1 masked", 32'(sci), 0);
        gpe_addr = 0; gpe_evt = 16'h0002; tick();
        chk("R6 slot hotplug sci", 32'(sci), 1);
        gpe_wr = 1; gpe_addr = 0; gpe_wdata = 8'h02; gpe_evt = 16'h0004; tick();
        chk("R6 cpu hotplug sci", 32'(sci), 1);
        gpe_wr = 1; gpe_addr = 0; gpe_wdata = 8'hFF; tick();
        chk("R5 gpe cleared", 32'(sci), 0);
        // R8/R9: command port
        apm_wr = 1; apm_cmd = 8'hF1; smi_gate = 1; tick();
        chk("R9 no smi on F1", 32'(smi_req), 0);
        apm_wr = 1; apm_cmd = 8'hF0; smi_gate = 1; tick();
        apm_wr = 1; apm_cmd = 8'h55; smi_gate = 1; tick();
        chk("R9 smi on other", 32'(smi_req), 1);
        apm_wr = 1; apm_cmd = 8'h55; smi_gate = 0; tick();

        // random phase
        for (int i = 0; i < 800; i++) begin
            pm1_evt    = 16'($urandom & $urandom & $urandom);
            pm1_sts_wr = ($urandom % 4) == 0;
            pm1_en_wr  = ($urandom % 6) == 0;
            pm1_wdata  = 16'($urandom);
            gpe_evt    = 16'($urandom & $urandom & $urandom);
            gpe_wr     = ($urandom % 3) == 0;
            gpe_addr   = 2'($urandom);
            gpe_wdata  = 8'($urandom);
            apm_wr     = ($urandom % 5) == 0;
            case ($urandom % 3)
                0: apm_cmd = 8'hF0;
                1: apm_cmd = 8'hF1;
                default: apm_cmd = 8'($urandom);
            endcase
            smi_gate = 1'($urandom);
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule